// File: doc/BRIEF.md
# Runtime-Selected Two-Input Bitwise Lookup Unit

This execution unit applies one two-input, one-output bitwise function to every bit lane of two 64-bit source operands. The function is not fixed in the instruction. Its 4-entry truth table is read at runtime out of a third 64-bit register operand. A nibble-select operand picks which nibble of that register holds the table. In each lane, the two source bits together form a 2-bit index, and that index picks one entry of the table.

The result is captured in a register. It is presented one cycle after a request is accepted, along with a valid strobe.

Software can build a dynamic three-input function from this unit. It issues the operation twice on the same sources and table register, once for each nibble. It then merges the two results with a bitwise multiplexer steered by a third operand. The low byte of the table register acts as an 8-entry table.

Top module: `dynLut2Unit`

## Requirements
- R1: While reset is active and after it is released with no request, `respValid` is 0 and `result` is all zeros.
- R2: `respValid` is 1 in the cycle after a cycle with `reqValid` high. It is 0 in the cycle after a cycle with `reqValid` low.
- R3: For each lane i, form idx = {srcB[i], srcA[i]}, with srcB as the most significant bit. The registered result bit i equals bit idx of the selected nibble, where nibble bit j is tableReg[4*nibSel + j].
- R4: With `nibSel` = 0, the table is tableReg[3:0], the least significant nibble.
- R5: With `nibSel` = 1, the table is tableReg[7:4], the next nibble up.
- R6: Bits of `tableReg` outside the selected nibble have no effect on `result`.
- R7: When `reqValid` is low, `result` holds its previous value.
- R8: Run once with `nibSel` = 0 and once with `nibSel` = 1 on the same operands, then merge per lane as (c ? second : first). The merged value equals a three-input lookup whose table is tableReg[7:0] and whose index is {c, srcB[i], srcA[i]}.
- R9: A selected nibble of all zeros gives an all-zero result, and one of all ones gives an all-ones result, whatever the sources are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; operands are sampled when high |
| srcA | input | 64 | First source; least significant bit of each lane index |
| srcB | input | 64 | Second source; most significant bit of each lane index |
| tableReg | input | 64 | Register that holds the truth-table nibbles |
| nibSel | input | 1 | Selects the nibble used as the truth table |
| respValid | output | 1 | Result valid, one cycle after a request |
| result | output | 64 | Registered per-lane lookup result |

## Verification
A corrupted capture strobe shows at the ports in the very next cycle. Either `respValid` goes out of step with the request, or `result` changes when no request came in.

A wrong nibble choice or a swapped index order shows in that same next cycle as wrong lanes. Random tables reach every one of the four index values in almost every request, so such a fault is exposed at once.

Leakage from the unselected table bits is caught by repeating a request with only those bits flipped. The two-pass merge then checks both nibble paths against a single three-input reference.

// File: rtl/dynLutPkg.sv
package dynLutPkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic capture;
  } lutStrobe_t;
endpackage

// File: rtl/dynLutCtrl.sv
module dynLutCtrl
  import dynLutPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output lutStrobe_t strobe,
  output logic       respValid
);
  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end
endmodule

// File: rtl/dynLutPath.sv
module dynLutPath
  import dynLutPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lutStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] tableReg,
  input  logic [SEL_W-1:0]  nibSel,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_NIB = 2 ** SEL_W;
  localparam int TBL_USED = NUM_NIB * NIB_W;

  logic [NIB_W-1:0]  nibArr [NUM_NIB];
  logic [NIB_W-1:0]  selNib;
  logic [DATA_W-1:0] laneOut;

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    assign nibArr[n] = tableReg[n*NIB_W +: NIB_W];
  end

  if (TBL_USED < DATA_W) begin : g_spare
    logic unusedTblHi;
    assign unusedTblHi = ^tableReg[DATA_W-1:TBL_USED];
  end

  assign selNib = nibArr[nibSel];

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic [1:0] laneIdx;
    assign laneIdx    = {srcB[i], srcA[i]};
    assign laneOut[i] = selNib[laneIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= laneOut;
  end
endmodule

// File: rtl/dynLut2Unit.sv
module dynLut2Unit
  import dynLutPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] tableReg,
  input  logic [SEL_W-1:0]  nibSel,
  output logic              respValid,
  output logic [DATA_W-1:0] result
);
  lutStrobe_t strobe;

  dynLutCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobe(strobe), .respValid(respValid)
  );

  dynLutPath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .tableReg(tableReg), .nibSel(nibSel),
    .result(result)
  );
endmodule

// File: rtl/dynLut2Checker.sv
module dynLut2Checker #(
  parameter int DATA_W = 64,
  parameter int SEL_W  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] tableReg,
  input logic [SEL_W-1:0]  nibSel,
  input logic              respValid,
  input logic [DATA_W-1:0] result
);
  function automatic logic [DATA_W-1:0] refLookup(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] t, input logic [SEL_W-1:0] s);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = t[4*int'(s) + 2*int'(b[i]) + int'(a[i])];
    return r;
  endfunction

  function automatic logic [3:0] pickNib(
    input logic [DATA_W-1:0] t, input logic [SEL_W-1:0] s);
    return t[4*int'(s) +: 4];
  endfunction

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(result));
  p_lane_lookup_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> result == refLookup($past(srcA), $past(srcB),
                                     $past(tableReg), $past(nibSel)));
  p_zero_table_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pickNib(tableReg, nibSel) == 4'h0) |=> result == '0);
  p_ones_table_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pickNib(tableReg, nibSel) == 4'hF) |=> result == '1);
endmodule

bind dynLut2Unit dynLut2Checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcA(srcA), .srcB(srcB),
  .tableReg(tableReg), .nibSel(nibSel), .respValid(respValid), .result(result)
);

// File: tb/dynLut2Unit_tb.sv
module dynLut2Unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] srcA = '0, srcB = '0, tableReg = '0;
  logic        nibSel = 1'b0;
  logic        respValid;
  logic [63:0] result;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  dynLut2Unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcA(srcA), .srcB(srcB),
    .tableReg(tableReg), .nibSel(nibSel), .respValid(respValid), .result(result)
  );

  function automatic logic [63:0] expLut2(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] t, input logic s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = t[(s ? 4 : 0) + (b[i] ? 2 : 0) + (a[i] ? 1 : 0)];
    return r;
  endfunction

  function automatic logic [63:0] expLut3(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] c, input logic [7:0] t);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = t[{c[i], b[i], a[i]}];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // one request; returns the captured result, checks R2/R7 around it
  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [63:0] t,
                       input logic s, output logic [63:0] got);
    logic [63:0] held;
    @(negedge clk);
    srcA = a; srcB = b; tableReg = t; nibSel = s; reqValid = 1'b1;
    @(negedge clk);
    check("R2 valid after request", {63'd0, respValid}, 64'd1);
    got = result;
    held = result;
    reqValid = 1'b0;
    srcA = ~a; srcB = ~b; tableReg = ~t; nibSel = ~s;
    @(negedge clk);
    check("R2 valid drops when idle", {63'd0, respValid}, 64'd0);
    check("R7 result held when idle", result, held);
  endtask

  initial begin
    #(20ns * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] got, got2, a, b, c, t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, respValid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {63'd0, respValid}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    // directed: AND, OR, XOR in low nibble; index order b:a
    a = 64'h00FF_00FF_F0F0_3333; b = 64'h0F0F_FF00_CCCC_5555;
    runOp(a, b, 64'h8, 1'b0, got); check("R4 AND in low nibble", got, a & b);
    runOp(a, b, 64'hE, 1'b0, got); check("R4 OR in low nibble", got, a | b);
    runOp(a, b, 64'h6, 1'b0, got); check("R3 XOR", got, a ^ b);
    runOp(a, b, 64'h2, 1'b0, got); check("R3 index order a&~b", got, a & ~b);
    runOp(a, b, 64'hA0, 1'b1, got); check("R5 copy a from high nibble", got, a);
    runOp(a, b, 64'hC0, 1'b1, got); check("R5 copy b from high nibble", got, b);
    runOp(a, b, 64'hFFFF_FFFF_FFFF_FF0F, 1'b1, got); check("R9 zero nibble", got, 64'd0);
    runOp(a, b, 64'h0000_0000_0000_000F, 1'b0, got); check("R9 ones nibble", got, '1);

    for (int k = 0; k < 300; k++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; t = {$urandom, $urandom};
      runOp(a, b, t, k[0], got);
      check("R3 random lookup", got, expLut2(a, b, t, k[0]));
      // R6: flip every bit outside the selected nibble
      runOp(a, b, t ^ (k[0] ? ~64'hF0 : ~64'hF), k[0], got2);
      check("R6 unselected table bits ignored", got2, got);
      if (k % 4 == 0) begin
        runOp(a, b, t, 1'b0, got);
        runOp(a, b, t, 1'b1, got2);
        check("R8 two-pass merge equals 3-input lookup",
              (got & ~c) | (got2 & c), expLut3(a, b, c, t[7:0]));
      end
    end
    summary();
  end
endmodule